// File: doc/BRIEF.md
# LED Driver Startup Sequencer

This block brings a flyback LED controller from power-up to steady regulation. It reads only digital flags: the supply is above its turn-on level, the supply has dropped below its turn-off level, the input line has crossed zero, the rectified input is above the phase-detect level, and a 1 kHz time-base tick. From these it walks through three line-synchronised startup phases, decides once whether a phase-cut dimmer sits in the line, and then settles into steady operation with the matching control scheme.

Phase one holds the maximum bleed current on until a minimum time has passed, then waits for a zero crossing. Phase two spans exactly one half line, and in it the sequencer measures how long the input stays below the phase-detect level after the crossing. Phase three runs the converter in low-peak current mode with the feedback clamp requested. Its minimum time counts only ticks in which the input is not cut, and it also ends on a zero crossing. After that, bleed is released, short-LED protection is armed, and either voltage-mode or constant-input-current control is selected. A restart pulse from the fault manager and a supply drop both return the block to its waiting state.

Top module: `led_start_seq`

## Requirements
- R1: After reset, and while in the waiting state, every output is low. The block leaves the waiting state only when `vdd_on` is high and `vdd_low` is low.
- R2: One clock edge after leaving the waiting state, `bleed_max` is high and every other output is low.
- R3: Phase one ends on a cycle where `zc` is high and at least `P1_MIN_TICKS` ticks were counted in earlier cycles of phase one. Any zero crossing before that is ignored.
- R4: Phase two ends at the first `zc` after it begins. During phase two, `bleed_max` stays high and the phase-three outputs stay low.
- R5: In phase two, ticks are counted while `vin_hi` is low, up to the first cycle in which `vin_hi` is high. `dim_mode` is latched to 1 when more than `DIM_GAP_TICKS` such ticks were counted before the ending `zc`, and to 0 otherwise.
- R6: In phase three, `lowpk_cm`, `fb_clamp_req` and `bleed_max` are high. `fb_clamp_angle` equals `dim_mode` (1 means a clamp proportional to phase angle, 0 means the fixed clamp). `dim_mode` does not change in phase three or afterwards.
- R7: Phase three ends on a `zc` cycle once at least `P3_MIN_TICKS` ticks with `vin_hi` high have been counted in earlier phase-three cycles. Ticks with `vin_hi` low are not counted.
- R8: In steady operation, `bleed_max`, `lowpk_cm` and `fb_clamp_req` are low and `short_prot_en` is high. Also, `vmode_en` is high when `dim_mode` is 0, and `cic_en` is high when `dim_mode` is 1.
- R9: `restart` high puts the block in the waiting state at the next edge, with `dim_mode` cleared, whatever else is happening.
- R10: `vdd_low` high puts the block in the waiting state at the next edge, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| restart | input | 1 | Synchronous return to waiting state from fault manager |
| vdd_on | input | 1 | Supply above turn-on threshold |
| vdd_low | input | 1 | Supply below turn-off threshold |
| zc | input | 1 | One-cycle input-line zero-crossing pulse |
| vin_hi | input | 1 | Input above phase-detect threshold |
| tick | input | 1 | One-cycle 1 kHz time-base pulse |
| bleed_max | output | 1 | Maximum bleed current enable |
| lowpk_cm | output | 1 | Low-peak current-mode enable |
| fb_clamp_req | output | 1 | Feedback clamp request |
| fb_clamp_angle | output | 1 | Clamp level select: 1 proportional to phase angle, 0 fixed |
| dim_mode | output | 1 | Latched dimmer-present decision |
| short_prot_en | output | 1 | Short-LED protection enable |
| vmode_en | output | 1 | Voltage-mode control select |
| cic_en | output | 1 | Constant input current control select |

## Verification
The hardest case to reach from the ports is one where the cut-aware count in phase three gives a different exit from a plain tick count. It only shows when a dimmer has already been detected and the half lines are cut. The stimulus builds whole half lines from 1 kHz ticks with a chosen cut width. A four-tick cut makes phase three last one half line longer than it would without the cut, and that extra half line is checked. A cut of exactly the threshold width probes the boundary of the dimmer decision.

// File: rtl/led_start_seq.sv
module led_start_seq #(
  parameter int P1_MIN_TICKS  = 12,
  parameter int P3_MIN_TICKS  = 15,
  parameter int DIM_GAP_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic vdd_on,
  input  logic vdd_low,
  input  logic zc,
  input  logic vin_hi,
  input  logic tick,
  output logic bleed_max,
  output logic lowpk_cm,
  output logic fb_clamp_req,
  output logic fb_clamp_angle,
  output logic dim_mode,
  output logic short_prot_en,
  output logic vmode_en,
  output logic cic_en
);
  localparam int MAXT = ((P1_MIN_TICKS > P3_MIN_TICKS) ? P1_MIN_TICKS : P3_MIN_TICKS)
                        + DIM_GAP_TICKS + 1;
  localparam int CW = $clog2(MAXT + 1);

  typedef enum logic [2:0] {S_IDLE, S_P1, S_P2, S_P3, S_RUN} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic          seen_hi;
  logic          dim_q;
  logic [CW-1:0] cnt_inc;

  assign cnt_inc = (&cnt) ? cnt : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      seen_hi <= 1'b0;
      dim_q   <= 1'b0;
    end else if (restart || vdd_low) begin
      state   <= S_IDLE;
      cnt     <= '0;
      seen_hi <= 1'b0;
      dim_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (vdd_on) begin
          state <= S_P1;
          cnt   <= '0;
        end
        S_P1: begin
          if (zc && cnt >= CW'(P1_MIN_TICKS)) begin
            state   <= S_P2;
            cnt     <= '0;
            seen_hi <= 1'b0;
          end else if (tick) cnt <= cnt_inc;
        end
        S_P2: begin
          if (zc) begin
            state <= S_P3;
            dim_q <= (cnt > CW'(DIM_GAP_TICKS));
            cnt   <= '0;
          end else begin
            if (vin_hi) seen_hi <= 1'b1;
            if (tick && !vin_hi && !seen_hi) cnt <= cnt_inc;
          end
        end
        S_P3: begin
          if (zc && cnt >= CW'(P3_MIN_TICKS)) state <= S_RUN;
          else if (tick && vin_hi) cnt <= cnt_inc;
        end
        default: state <= S_RUN;
      endcase
    end
  end

  assign bleed_max      = (state == S_P1) || (state == S_P2) || (state == S_P3);
  assign lowpk_cm       = (state == S_P3);
  assign fb_clamp_req   = (state == S_P3);
  assign fb_clamp_angle = (state == S_P3) && dim_q;
  assign dim_mode       = dim_q;
  assign short_prot_en  = (state == S_RUN);
  assign vmode_en       = (state == S_RUN) && !dim_q;
  assign cic_en         = (state == S_RUN) && dim_q;

  assert_p1_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_P2 && $past(state) == S_P1) |-> ($past(zc) && $past(cnt) >= CW'(P1_MIN_TICKS)));

  assert_p3_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && $past(state) == S_P3) |-> ($past(zc) && $past(cnt) >= CW'(P3_MIN_TICKS)));

  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_P3 || state == S_RUN) && ($past(state) == S_P3 || $past(state) == S_RUN))
      |-> $stable(dim_q));

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(restart) |-> (state == S_IDLE && !dim_q));

  assert_uvlo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(vdd_low) |-> (state == S_IDLE));
endmodule

// File: tb/led_start_seq_test.sv
module led_start_seq_test;
  logic clk = 0, rst_n = 0;
  logic restart = 0, vdd_on = 0, vdd_low = 0, zc = 0, vin_hi = 0, tick = 0;
  logic bleed_max, lowpk_cm, fb_clamp_req, fb_clamp_angle, dim_mode;
  logic short_prot_en, vmode_en, cic_en;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  led_start_seq uut (.clk(clk), .rst_n(rst_n), .restart(restart), .vdd_on(vdd_on),
    .vdd_low(vdd_low), .zc(zc), .vin_hi(vin_hi), .tick(tick), .bleed_max(bleed_max),
    .lowpk_cm(lowpk_cm), .fb_clamp_req(fb_clamp_req), .fb_clamp_angle(fb_clamp_angle),
    .dim_mode(dim_mode), .short_prot_en(short_prot_en), .vmode_en(vmode_en), .cic_en(cic_en));

  // behavioural reference: 0 wait, 1 phase one, 2 phase two, 3 phase three, 4 running
  int ms = 0, mc = 0, mdim = 0;
  bit mseen = 0;
  always @(posedge clk) begin
    if (!rst_n) begin ms = 0; mc = 0; mdim = 0; mseen = 0; end
    else if (restart || vdd_low) begin ms = 0; mc = 0; mdim = 0; mseen = 0; end
    else if (ms == 0) begin if (vdd_on) begin ms = 1; mc = 0; end end
    else if (ms == 1) begin
      if (zc && mc >= 12) begin ms = 2; mc = 0; mseen = 0; end
      else if (tick) mc++;
    end else if (ms == 2) begin
      if (zc) begin ms = 3; mdim = (mc > 2); mc = 0; end
      else begin
        if (tick && !vin_hi && !mseen) mc++;
        if (vin_hi) mseen = 1;
      end
    end else if (ms == 3) begin
      if (zc && mc >= 15) ms = 4;
      else if (tick && vin_hi) mc++;
    end
  end

  function automatic string tag_of(int s);
    case (s)
      0: return "R1"; 1: return "R3"; 2: return "R4"; 3: return "R7"; default: return "R8";
    endcase
  endfunction

  always @(negedge clk) if (rst_n && !done) begin
    logic [7:0] got, exp;
    got = {bleed_max, lowpk_cm, fb_clamp_req, fb_clamp_angle, dim_mode, short_prot_en, vmode_en, cic_en};
    exp = {(ms >= 1 && ms <= 3), ms == 3, ms == 3, (ms == 3 && mdim != 0), mdim != 0,
           ms == 4, (ms == 4 && mdim == 0), (ms == 4 && mdim != 0)};
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s cycle compare: got %b expected %b", tag_of(ms), got, exp);
    end
  end

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic cyc(bit z, bit t, bit v);
    @(negedge clk);
    zc = z; tick = t; vin_hi = v;
  endtask

  task automatic half_line(int cut);
    for (int t = 0; t < 10; t++)
      for (int c = 0; c < 4; c++)
        cyc(t == 0 && c == 0, c == 1, t >= cut);
  endtask

  function automatic logic [7:0] outs();
    return {bleed_max, lowpk_cm, fb_clamp_req, fb_clamp_angle, dim_mode, short_prot_en, vmode_en, cic_en};
  endfunction

  task automatic report();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) cyc(0, 1, 0);
    chk("R1 idle without vdd_on", outs(), 8'b0);
    @(negedge clk); vdd_on = 1;
    cyc(0, 0, 1);
    chk("R2 phase one entry", outs(), 8'b1000_0000);
    // non-dimmed line
    half_line(0); half_line(0); half_line(0); cyc(0, 0, 1);
    chk("R3 early crossings ignored, phase two", outs(), 8'b1000_0000);
    half_line(0); cyc(0, 0, 1);
    chk("R6 phase three fixed clamp", outs(), 8'b1110_0000);
    half_line(0); cyc(0, 0, 1);
    chk("R7 phase three holds before minimum", outs(), 8'b1110_0000);
    half_line(0); cyc(0, 0, 1);
    chk("R8 running voltage mode", outs(), 8'b0000_0110);
    // restart
    @(negedge clk); restart = 1;
    @(negedge clk); restart = 0;
    chk("R9 restart to wait", outs(), 8'b0);
    // dimmed line, cut of 4 ticks
    half_line(4); half_line(4); half_line(4); cyc(0, 0, 1);
    chk("R4 phase two dimmed line", outs(), 8'b1000_0000);
    half_line(4); cyc(0, 0, 1);
    chk("R5 dimmer detected, angle clamp", outs(), 8'b1111_1000);
    half_line(4); half_line(4); cyc(0, 0, 1);
    chk("R7 cut ticks not counted", outs(), 8'b1111_1000);
    half_line(4); cyc(0, 0, 1);
    chk("R8 running input current control", outs(), 8'b0000_1101);
    // boundary cut equal to threshold
    @(negedge clk); restart = 1;
    @(negedge clk); restart = 0;
    half_line(2); half_line(2); half_line(2); half_line(2); cyc(0, 0, 1);
    chk("R5 cut at threshold not dimmed", outs(), 8'b1110_0000);
    @(negedge clk); vdd_low = 1;
    @(negedge clk); vdd_low = 0;
    chk("R10 supply drop to wait", outs(), 8'b0);
    @(negedge clk);
    chk("R2 re-entry after supply drop", outs(), 8'b1000_0000);
    repeat (2) @(negedge clk);
    report();
  end
endmodule